// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller Core

This block is the arbitration heart of an eight-line interrupt controller. It keeps a pending-request register, an in-service register, a mask register, a per-line trigger-mode register and a rotation base. It captures requests from the interrupt inputs, either as edges or as levels. It then decides which unmasked pending line ranks highest under the current rotation. When that line outranks everything currently in service, it raises the interrupt output.

The surrounding controller handles register decode, cascading and vector formation. It drives this core through a few simple ports. An acknowledge strobe carries a line index, normally the winning line the core reports. A command strobe carries an end-of-interrupt or priority-setting opcode together with a line index. Two load strobes write the mask and the trigger mode. Four level inputs select the operating mode: automatic end of interrupt, rotation on automatic end of interrupt, special fully nested operation, and whether this instance is the master of a cascade. The request and in-service registers and the rotation base are brought out so that the wrapper can read them back.

Top module: `rpic_core`

## Requirements
- R1: A synchronous active-high reset clears the request, in-service, mask, trigger-mode and edge-history registers and sets the rotation base to 0, so `int_out` is low.
- R2: For a level line (trigger bit 1), the request bit equals the input as sampled at the previous clock edge, and an acknowledge never clears it.
- R3: For an edge line (trigger bit 0), the request bit is set when the input is high and the stored previous level is low. A falling input only updates the stored level. An acknowledge of that line clears the bit, unless a new rising edge arrives in the same cycle.
- R4: Priority p = 0..7 maps to line (p + base) mod 8, with p = 0 the highest. `win_line` is the line of the best unmasked pending request.
- R5: `int_out` is high exactly when the best unmasked pending priority is strictly smaller than the best in-service priority, where an empty set counts as 8. Masked lines still latch into the request register.
- R6: With `sfnm_en` and `is_master` both high, in-service bit 2 is left out of the in-service priority used for R5.
- R7: `ack_stb` with `auto_eoi` low sets in-service bit `ack_line` at the next edge.
- R8: `ack_stb` with `auto_eoi` high leaves in-service bit `ack_line` clear. If `rot_auto_eoi` is also high, the base becomes (`ack_line` + 1) mod 8.
- R9: `cmd` = 0 clears the highest-priority in-service bit, with all in-service bits considered. `cmd` = 1 does the same and also sets the base to that line + 1 mod 8. With nothing in service, neither command changes anything.
- R10: `cmd` = 2 clears in-service bit `cmd_line`. `cmd` = 4 sets the base to (`cmd_line` + 1) mod 8. `cmd` = 3 does both. Codes 5 to 7 change nothing.
- R11: When `cmd_stb` and `ack_stb` are high in the same cycle, the acknowledge is applied and the command is ignored.
- R12: `mask_we` loads `mask_wdata` into the mask (bit 1 = masked), and `trig_we` loads `trig_wdata` into the trigger-mode register, both at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Interrupt request inputs |
| trig_we | input | 1 | Load strobe for the trigger-mode register |
| trig_wdata | input | 8 | Trigger modes, 1 = level, 0 = edge |
| mask_we | input | 1 | Load strobe for the mask register |
| mask_wdata | input | 8 | Mask bits, 1 = masked |
| auto_eoi | input | 1 | Automatic end of interrupt at acknowledge |
| rot_auto_eoi | input | 1 | Rotate the base on automatic end of interrupt |
| sfnm_en | input | 1 | Special fully nested mode |
| is_master | input | 1 | Instance is the cascade master |
| ack_stb | input | 1 | Acknowledge strobe |
| ack_line | input | 3 | Line being acknowledged |
| cmd_stb | input | 1 | Command strobe |
| cmd | input | 3 | Command code (0..4 defined) |
| cmd_line | input | 3 | Line or level operand of the command |
| int_out | output | 1 | Interrupt output to the processor side |
| win_line | output | 3 | Best unmasked pending line |
| irr_o | output | 8 | Request register |
| isr_o | output | 8 | In-service register |
| base_o | output | 3 | Rotation base |

## Verification
The bench targets the strict comparison, where a pending line of equal priority to one in service must not raise `int_out`; a non-strict design would re-interrupt its own handler. It targets the split between edge and level lines on acknowledge: clearing a level line's request would lose an asserted level, and keeping an edge line's request would deliver the interrupt twice. It checks rotation through all three paths that move the base, since a design that rotated off the old base would pick the wrong winner afterwards. It also checks the master-only exclusion of bit 2, where ignoring `is_master` would let a cascade input pre-empt a slave's handler on a slave instance.

// File: rtl/rpic_pkg.sv
package rpic_pkg;
  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_EOI_TOP     = 3'd0,
    CMD_EOI_TOP_ROT = 3'd1,
    CMD_EOI_LINE    = 3'd2,
    CMD_EOI_LINE_RT = 3'd3,
    CMD_SET_BASE    = 3'd4
  } rpic_cmd_e;
endpackage

// File: rtl/rpic_prio_find.sv
// Rotating priority search: priority p maps to line (p + base) mod N.
module rpic_prio_find #(
  parameter int NLINES = 8,
  localparam int LW = $clog2(NLINES)
) (
  input  logic [NLINES-1:0] req,
  input  logic [LW-1:0]     base,
  output logic [LW:0]       prio,   // NLINES means none
  output logic [LW-1:0]     line
);
  logic [NLINES-1:0] rot;
  logic [LW-1:0]     idx;

  always_comb begin
    rot = '0;
    idx = '0;
    for (int i = 0; i < NLINES; i++) begin
      idx    = LW'(i) + base;
      rot[i] = req[idx];
    end
  end

  always_comb begin
    prio = (LW+1)'(NLINES);
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (rot[i]) prio = (LW+1)'(i);
    end
    line = prio[LW-1:0] + base;
  end
endmodule

// File: rtl/rpic_req_stage.sv
// Request capture: level lines follow the input, edge lines latch rising edges.
module rpic_req_stage #(
  parameter int NLINES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] irq_in,
  input  logic [NLINES-1:0] trig,     // 1 = level
  input  logic [NLINES-1:0] ack_clr,  // one-hot acknowledge
  output logic [NLINES-1:0] irr
);
  logic [NLINES-1:0] hist_q;
  logic [NLINES-1:0] irr_q;
  logic [NLINES-1:0] edge_set;
  logic [NLINES-1:0] edge_next;

  assign edge_set  = irq_in & ~hist_q;
  assign edge_next = (irr_q & ~ack_clr) | edge_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      irr_q  <= '0;
    end else begin
      hist_q <= irq_in;
      irr_q  <= (trig & irq_in) | (~trig & edge_next);
    end
  end

  assign irr = irr_q;
endmodule

// File: rtl/rpic_service_stage.sv
// In-service register and rotation base, updated by acknowledge and commands.
module rpic_service_stage
  import rpic_pkg::*;
#(
  parameter int NLINES = 8,
  localparam int LW = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack_stb,
  input  logic [LW-1:0]     ack_line,
  input  logic              auto_eoi,
  input  logic              rot_auto_eoi,
  input  logic              cmd_stb,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [LW-1:0]     cmd_line,
  input  logic              top_found,
  input  logic [LW-1:0]     top_line,
  output logic [NLINES-1:0] isr,
  output logic [LW-1:0]     base
);
  logic [NLINES-1:0] isr_q, isr_n;
  logic [LW-1:0]     base_q, base_n;
  rpic_cmd_e         op;

  assign op = rpic_cmd_e'(cmd);

  always_comb begin
    isr_n  = isr_q;
    base_n = base_q;
    if (ack_stb) begin
      if (auto_eoi) begin
        isr_n[ack_line] = 1'b0;
        if (rot_auto_eoi) base_n = ack_line + 1'b1;
      end else begin
        isr_n[ack_line] = 1'b1;
      end
    end else if (cmd_stb) begin
      case (op)
        CMD_EOI_TOP: begin
          if (top_found) isr_n[top_line] = 1'b0;
        end
        CMD_EOI_TOP_ROT: begin
          if (top_found) begin
            isr_n[top_line] = 1'b0;
            base_n          = top_line + 1'b1;
          end
        end
        CMD_EOI_LINE: isr_n[cmd_line] = 1'b0;
        CMD_EOI_LINE_RT: begin
          isr_n[cmd_line] = 1'b0;
          base_n          = cmd_line + 1'b1;
        end
        CMD_SET_BASE: base_n = cmd_line + 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q  <= '0;
      base_q <= '0;
    end else begin
      isr_q  <= isr_n;
      base_q <= base_n;
    end
  end

  assign isr  = isr_q;
  assign base = base_q;
endmodule

// File: rtl/rpic_core.sv
module rpic_core
  import rpic_pkg::*;
#(
  parameter int NLINES       = 8,
  parameter int CASCADE_LINE = 2,
  localparam int LW = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] irq_in,
  input  logic              trig_we,
  input  logic [NLINES-1:0] trig_wdata,
  input  logic              mask_we,
  input  logic [NLINES-1:0] mask_wdata,
  input  logic              auto_eoi,
  input  logic              rot_auto_eoi,
  input  logic              sfnm_en,
  input  logic              is_master,
  input  logic              ack_stb,
  input  logic [LW-1:0]     ack_line,
  input  logic              cmd_stb,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [LW-1:0]     cmd_line,
  output logic              int_out,
  output logic [LW-1:0]     win_line,
  output logic [NLINES-1:0] irr_o,
  output logic [NLINES-1:0] isr_o,
  output logic [LW-1:0]     base_o
);
  localparam logic [NLINES-1:0] CASC_BIT = NLINES'(1) << CASCADE_LINE;

  logic [NLINES-1:0] mask_q, trig_q;
  logic [NLINES-1:0] ack_clr, pend, isr_cmp;
  logic [LW:0]       pend_prio, cur_prio, top_prio;
  logic [LW-1:0]     pend_line, cur_line, top_line;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      trig_q <= '0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      if (trig_we) trig_q <= trig_wdata;
    end
  end

  assign ack_clr = ack_stb ? (NLINES'(1) << ack_line) : '0;

  rpic_req_stage #(.NLINES(NLINES)) u_req (
    .clk(clk), .rst(rst), .irq_in(irq_in), .trig(trig_q),
    .ack_clr(ack_clr), .irr(irr_o)
  );

  assign pend    = irr_o & ~mask_q;
  assign isr_cmp = (sfnm_en && is_master) ? (isr_o & ~CASC_BIT) : isr_o;

  rpic_prio_find #(.NLINES(NLINES)) u_pend_find (
    .req(pend), .base(base_o), .prio(pend_prio), .line(pend_line)
  );
  rpic_prio_find #(.NLINES(NLINES)) u_cur_find (
    .req(isr_cmp), .base(base_o), .prio(cur_prio), .line(cur_line)
  );
  rpic_prio_find #(.NLINES(NLINES)) u_top_find (
    .req(isr_o), .base(base_o), .prio(top_prio), .line(top_line)
  );

  rpic_service_stage #(.NLINES(NLINES)) u_svc (
    .clk(clk), .rst(rst), .ack_stb(ack_stb), .ack_line(ack_line),
    .auto_eoi(auto_eoi), .rot_auto_eoi(rot_auto_eoi),
    .cmd_stb(cmd_stb), .cmd(cmd), .cmd_line(cmd_line),
    .top_found(top_prio != (LW+1)'(NLINES)), .top_line(top_line),
    .isr(isr_o), .base(base_o)
  );

  assign int_out  = pend_prio < cur_prio;
  assign win_line = pend_line;
endmodule

// File: rtl/rpic_core_chk.sv
module rpic_core_chk #(
  parameter int NLINES = 8,
  localparam int LW = $clog2(NLINES)
) (
  input logic              clk,
  input logic              rst,
  input logic [NLINES-1:0] irq_in,
  input logic              ack_stb,
  input logic [LW-1:0]     ack_line,
  input logic              auto_eoi,
  input logic              rot_auto_eoi,
  input logic              cmd_stb,
  input logic [2:0]        cmd,
  input logic [LW-1:0]     cmd_line,
  input logic              int_out,
  input logic [LW-1:0]     win_line,
  input logic [NLINES-1:0] irr_o,
  input logic [NLINES-1:0] isr_o,
  input logic [LW-1:0]     base_o,
  input logic [NLINES-1:0] mask_q,
  input logic [NLINES-1:0] trig_q
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (irr_o == '0 && isr_o == '0 && base_o == '0 && !int_out));

  // R2
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((irr_o & $past(trig_q)) == ($past(irq_in) & $past(trig_q))));

  // R4
  winner_pending_chk: assert property (@(posedge clk) disable iff (rst)
    int_out |-> (irr_o[win_line] && !mask_q[win_line]));

  // R7
  ack_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_stb && !auto_eoi) |=> isr_o[$past(ack_line)]);

  // R8
  auto_rotate_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_stb && auto_eoi && rot_auto_eoi) |=> (base_o == LW'($past(ack_line) + 1'b1)));

  // R10
  set_base_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && !ack_stb && cmd == 3'd4) |=> (base_o == LW'($past(cmd_line) + 1'b1)));

  // R11
  cmd_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_stb && cmd_stb && !(auto_eoi && rot_auto_eoi)) |=> $stable(base_o));
endmodule

bind rpic_core rpic_core_chk #(.NLINES(NLINES)) u_chk (
  .clk(clk), .rst(rst), .irq_in(irq_in), .ack_stb(ack_stb), .ack_line(ack_line),
  .auto_eoi(auto_eoi), .rot_auto_eoi(rot_auto_eoi), .cmd_stb(cmd_stb),
  .cmd(cmd), .cmd_line(cmd_line), .int_out(int_out), .win_line(win_line),
  .irr_o(irr_o), .isr_o(isr_o), .base_o(base_o), .mask_q(mask_q), .trig_q(trig_q)
);

// File: tb/rpic_core_tb.sv
module rpic_core_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       trig_we = 0, mask_we = 0;
  logic [7:0] trig_wdata = '0, mask_wdata = '0;
  logic       auto_eoi = 0, rot_auto_eoi = 0, sfnm_en = 0, is_master = 0;
  logic       ack_stb = 0, cmd_stb = 0;
  logic [2:0] ack_line = '0, cmd = '0, cmd_line = '0;
  logic       int_out;
  logic [2:0] win_line, base_o;
  logic [7:0] irr_o, isr_o;

  int tests = 0, fails = 0;
  bit cmp_on = 0;

  always #5 clk = ~clk;

  rpic_core u_dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .trig_we(trig_we), .trig_wdata(trig_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .auto_eoi(auto_eoi),
    .rot_auto_eoi(rot_auto_eoi), .sfnm_en(sfnm_en), .is_master(is_master),
    .ack_stb(ack_stb), .ack_line(ack_line), .cmd_stb(cmd_stb), .cmd(cmd),
    .cmd_line(cmd_line), .int_out(int_out), .win_line(win_line),
    .irr_o(irr_o), .isr_o(isr_o), .base_o(base_o)
  );

  // Behavioural reference model
  bit [7:0] m_irr, m_isr, m_mask, m_trig, m_hist;
  int       m_base;
  bit [7:0] n_irr, n_isr;
  int       n_base, t_p;

  function automatic int mprio(bit [7:0] m, int b);
    for (int p = 0; p < 8; p++) if (m[(p + b) % 8]) return p;
    return 8;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_irr = 0; m_isr = 0; m_mask = 0; m_trig = 0; m_hist = 0; m_base = 0;
    end else begin
      n_isr = m_isr; n_base = m_base;
      for (int l = 0; l < 8; l++) begin
        if (m_trig[l]) n_irr[l] = irq_in[l];
        else begin
          n_irr[l] = (ack_stb && ack_line == l) ? 1'b0 : m_irr[l];
          if (irq_in[l] && !m_hist[l]) n_irr[l] = 1'b1;
        end
      end
      if (ack_stb) begin
        if (auto_eoi) begin
          n_isr[ack_line] = 0;
          if (rot_auto_eoi) n_base = (ack_line + 1) % 8;
        end else n_isr[ack_line] = 1;
      end else if (cmd_stb) begin
        t_p = mprio(m_isr, m_base);
        if (cmd == 0 && t_p < 8) n_isr[(t_p + m_base) % 8] = 0;
        if (cmd == 1 && t_p < 8) begin
          n_isr[(t_p + m_base) % 8] = 0;
          n_base = ((t_p + m_base) % 8 + 1) % 8;
        end
        if (cmd == 2 || cmd == 3) n_isr[cmd_line] = 0;
        if (cmd == 3 || cmd == 4) n_base = (cmd_line + 1) % 8;
      end
      m_irr = n_irr; m_isr = n_isr; m_base = n_base; m_hist = irq_in;
      if (mask_we) m_mask = mask_wdata;
      if (trig_we) m_trig = trig_wdata;
    end
  end

  function automatic bit m_int();
    bit [7:0] c;
    c = m_isr;
    if (sfnm_en && is_master) c[2] = 0;
    return mprio(m_irr & ~m_mask, m_base) < mprio(c, m_base);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model, away from the active edge
  always @(negedge clk) if (cmp_on) begin
    chk("R2 R3", "irr", irr_o, m_irr);
    chk("R7 R8 R9 R10 R11", "isr", isr_o, m_isr);
    chk("R8 R9 R10", "base", base_o, m_base);
    chk("R5 R6 R12", "int_out", int_out, m_int());
    if (m_int()) chk("R4", "win_line", win_line, (mprio(m_irr & ~m_mask, m_base) + m_base) % 8);
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic clear_strobes();
    ack_stb = 0; cmd_stb = 0; mask_we = 0; trig_we = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state (reset held, then checked)
    chk("R1", "irr", irr_o, 0);
    chk("R1", "isr", isr_o, 0);
    chk("R1", "base", base_o, 0);
    chk("R1", "int_out", int_out, 0);
    rst = 0;
    cmp_on = 1;
    step();
    // R3 edge line 3 rises
    irq_in = 8'h08; step();
    chk("R3", "irr after rise", irr_o, 8'h08);
    chk("R5", "int_out on pending", int_out, 1);
    chk("R4", "win_line", win_line, 3);
    irq_in = 8'h00; step();
    chk("R3", "irr after fall", irr_o, 8'h08);
    // R7 acknowledge line 3
    ack_stb = 1; ack_line = 3; step(); clear_strobes();
    chk("R7", "isr after ack", isr_o, 8'h08);
    chk("R3", "edge cleared by ack", irr_o, 8'h00);
    // R5 lower-priority line 5 does not interrupt
    irq_in = 8'h20; step();
    chk("R5", "lower pending no int", int_out, 0);
    // R10 set-priority cmd 4 with level 4 -> base 5
    cmd_stb = 1; cmd = 4; cmd_line = 4; step(); clear_strobes();
    chk("R10", "base after set", base_o, 5);
    chk("R4", "rotated winner", win_line, 5);
    chk("R5", "int after rotation", int_out, 1);
    // R12 mask line 5
    mask_we = 1; mask_wdata = 8'h20; step(); clear_strobes();
    chk("R12", "masked line no int", int_out, 0);
    chk("R5", "masked still latched", irr_o, 8'h20);
    // R2 level line 0
    trig_we = 1; trig_wdata = 8'h01; irq_in = 8'h21; step(); clear_strobes();
    step();
    chk("R2", "level request", irr_o[0], 1);
    ack_stb = 1; ack_line = 0; step(); clear_strobes();
    chk("R2", "level kept after ack", irr_o[0], 1);
    irq_in = 8'h20; step();
    chk("R2", "level drop", irr_o[0], 0);
    // R9 non-specific EOI clears line 0 first (base 5: line 0 is p3, line 3 is p6)
    cmd_stb = 1; cmd = 0; step(); clear_strobes();
    chk("R9", "nseoi", isr_o, 8'h08);
    // R11 command blocked by simultaneous ack
    ack_stb = 1; ack_line = 6; cmd_stb = 1; cmd = 4; cmd_line = 0; step(); clear_strobes();
    chk("R11", "base unchanged", base_o, 5);
    chk("R11", "ack applied", isr_o, 8'h48);
    // R8 auto-EOI with rotation
    auto_eoi = 1; rot_auto_eoi = 1; ack_stb = 1; ack_line = 2; step(); clear_strobes();
    chk("R8", "auto eoi base", base_o, 3);
    chk("R8", "auto eoi isr", isr_o, 8'h48);
    auto_eoi = 0; rot_auto_eoi = 0;
    // R6 special fully nested on master: isr bit 2 ignored
    cmd_stb = 1; cmd = 2; cmd_line = 3; step();
    cmd = 2; cmd_line = 6; step(); clear_strobes();
    mask_we = 1; mask_wdata = 8'h00; trig_we = 1; trig_wdata = 8'h00; irq_in = 0; step();
    clear_strobes();
    ack_stb = 1; ack_line = 2; step(); clear_strobes();   // isr = bit 2, base 3
    cmd_stb = 1; cmd = 4; cmd_line = 7; step(); clear_strobes(); // base 0
    irq_in = 8'h04; step();                              // line 2 pending, equal priority
    sfnm_en = 1; is_master = 0; step();
    chk("R6", "slave keeps strict compare", int_out, 0);
    is_master = 1; step();
    chk("R6", "master ignores bit 2", int_out, 1);
    sfnm_en = 0; is_master = 0;
    // Random phase
    for (int i = 0; i < 4000; i++) begin
      clear_strobes();
      if ($urandom_range(0, 3) == 0) irq_in = 8'($urandom);
      if ($urandom_range(0, 4) == 0) begin
        ack_stb = 1;
        ack_line = ($urandom_range(0, 1) == 0) ? win_line : 3'($urandom);
      end
      if ($urandom_range(0, 4) == 0) begin
        cmd_stb = 1; cmd = 3'($urandom); cmd_line = 3'($urandom);
      end
      if ($urandom_range(0, 40) == 0) begin mask_we = 1; mask_wdata = 8'($urandom); end
      if ($urandom_range(0, 40) == 0) begin trig_we = 1; trig_wdata = 8'($urandom); end
      if ($urandom_range(0, 60) == 0) begin
        auto_eoi = 1'($urandom); rot_auto_eoi = 1'($urandom);
        sfnm_en = 1'($urandom); is_master = 1'($urandom);
      end
      step();
    end
    clear_strobes();
    step();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule